// File: doc/BRIEF.md
# Semaphore-Gated Descriptor Channel Controller

This block runs up to four independent command channels that share one processing engine. Software sets a channel's command pointer to a descriptor in memory, adds work credits to the channel's counting semaphore and enables the channel. The controller then reads the eight-word descriptor over a simple memory port and hands its control, address and size words to the engine. When the engine finishes, the controller writes the engine's result code back into the descriptor and updates the semaphore, the pointer and the interrupt flags.

Channels can chain descriptors through the first word of each one. A channel keeps working only while it is enabled, holds credit and has a nonzero link. Between descriptors, the next one to run goes to the lowest-numbered eligible channel. The cipher and hash datapaths are not part of this block. The engine port is only a start and done handshake that returns an 8-bit result code.

Top module: `cmdchan_ctrl`

## Requirements
- R1: After reset, irq is low and neither mem_req nor eng_start is asserted. The pending word, the enable register, every semaphore and every channel status read back as zero.
- R2: A read returns its data on reg_rdata in the cycle after reg_rd. Global registers sit at 0x10 (pending flags in bits NCH-1:0), 0x18 (clear-pending) and 0x20 (enable, low 8 bits readable). Channel n sits at 0x100+0x40*n: +0x00 command pointer, +0x10 semaphore, +0x20 status (code in bits 7:0), +0x28 status clear.
- R3: A write to the semaphore register adds the written value to the count. The count saturates at 255, and a read returns the current count.
- R4: A channel that is enabled, has a nonzero count and is not halted reads eight words from its pointer, ascending by 4: link, control0, control1, source, destination, size, payload, status. Request and address hold until mem_ack.
- R5: A channel whose enable bit is clear never starts a descriptor, whatever its count.
- R6: One cycle after the eighth word is accepted, eng_start pulses for a single cycle. At the same time eng_ctrl0, eng_ctrl1, eng_src, eng_dst, eng_size and eng_payload show words 1 to 6. Only one descriptor is in the engine at a time, and there is no memory traffic while it runs.
- R7: After eng_done, the engine's code is written, zero-extended, to pointer+28.
- R8: On success, control0 bit 1 decrements the count and control0 bit 0 sets the channel's pending flag. A nonzero link replaces the channel's pointer.
- R9: A channel continues along its chain while the link is nonzero and its count is above zero. A zero link halts the channel with its count kept, until software writes its pointer or semaphore.
- R10: A nonzero engine code goes into the channel status low byte and sets the pending flag whatever control0 says. It does not decrement the count, does not follow the link and halts the channel. Writing ones to +0x28 clears the matching status bits.
- R11: The lowest-numbered eligible channel is served first, and the choice is made again after every descriptor.
- R12: irq is the OR of the pending flags. It rises the cycle after the status write is accepted. Writing ones to 0x18 clears the matching flags, and a flag being set by hardware in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, one cycle after reg_rd |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | DW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| eng_start | output | 1 | Engine start pulse |
| eng_ctrl0 | output | DW | Descriptor control word 0 |
| eng_ctrl1 | output | DW | Descriptor control word 1 |
| eng_src | output | DW | Source address |
| eng_dst | output | DW | Destination address |
| eng_size | output | DW | Transfer size |
| eng_payload | output | DW | Payload pointer |
| eng_done | input | 1 | Engine finished |
| eng_err | input | EW | Engine result code, 0 means success |
| irq | output | 1 | Interrupt, OR of pending flags |

## Verification
Each result has its own due cycle. Register data is due one edge after the read strobe. A pending flag and irq are due one edge after the accepted status write, and a clear takes effect at the edge that latches the write. eng_start follows the eighth accepted fetch word by one edge. The bench's reference model runs on the falling edge. It first compares irq with the flags it predicted for the edge just passed, then works out what the coming edge commits from the strobes and memory writes it sees. A memory and engine responder driven on that same falling edge keeps every sample half a cycle away from the edge that commits it.

// File: rtl/cmdchan_pkg.sv
package cmdchan_pkg;
    localparam int DESC_WORDS = 8;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_START = 3'd2,
        S_WAIT  = 3'd3,
        S_WB    = 3'd4
    } seq_e;

    // global register offsets (reg_addr[7:0] when reg_addr[11:8] == 0)
    localparam logic [7:0] G_PEND = 8'h10;
    localparam logic [7:0] G_CLR  = 8'h18;
    localparam logic [7:0] G_EN   = 8'h20;

    // per-channel offsets (reg_addr[5:0] when reg_addr[11:8] == 1)
    localparam logic [5:0] C_PTR  = 6'h00;
    localparam logic [5:0] C_SEMA = 6'h10;
    localparam logic [5:0] C_STAT = 6'h20;
    localparam logic [5:0] C_SCLR = 6'h28;

    // descriptor word positions that the sequencer decodes
    localparam int W_LINK = 0;
    localparam int W_CTL0 = 1;
    localparam int W_STAT = 7;
endpackage

// File: rtl/cmdchan_sema.sv
module cmdchan_sema #(
    parameter int CW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add_en,
    input  logic [DW-1:0] add_val,
    input  logic          dec,
    output logic [CW-1:0] count
);
    localparam logic [DW:0] MAXV = {{(DW+1-CW){1'b0}}, {CW{1'b1}}};

    logic [CW-1:0] cnt_q, cnt_d, base;
    logic [DW:0]   sum;

    always_comb begin
        base  = cnt_q - CW'(dec && (cnt_q != '0));
        sum   = {{(DW+1-CW){1'b0}}, base} + (add_en ? {1'b0, add_val} : '0);
        cnt_d = (sum > MAXV) ? {CW{1'b1}} : sum[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/cmdchan_pick.sv
module cmdchan_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/cmdchan_ctrl.sv
module cmdchan_ctrl
    import cmdchan_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 32,
    parameter int CW  = 8,
    parameter int EW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [11:0]   reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          eng_start,
    output logic [DW-1:0] eng_ctrl0,
    output logic [DW-1:0] eng_ctrl1,
    output logic [DW-1:0] eng_src,
    output logic [DW-1:0] eng_dst,
    output logic [DW-1:0] eng_size,
    output logic [DW-1:0] eng_payload,
    input  logic          eng_done,
    input  logic [EW-1:0] eng_err,
    output logic          irq
);
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int KEEPW = DESC_WORDS - 1;   // status word is not kept
    localparam int IDXW  = $clog2(DESC_WORDS);

    typedef struct packed {
        seq_e                       st;
        logic [CHW-1:0]             ch;
        logic [IDXW-1:0]            idx;
        logic [DW-1:0]              base;
        logic [KEEPW-1:0][DW-1:0]   desc;
        logic [EW-1:0]              err;
        logic [NCH-1:0]             pend;
        logic [NCH-1:0]             park;
        logic [NCH-1:0][EW-1:0]     cerr;
        logic [NCH-1:0][DW-1:0]     cptr;
        logic [7:0]                 en;
        logic [DW-1:0]              rdata;
    } state_t;

    state_t q, d;

    logic                     is_glb, ch_ok;
    logic [CHW-1:0]           acc_ch;
    logic [5:0]               off;
    logic [NCH-1:0]           sema_wr, sema_dec, elig, hw_set;
    logic [NCH-1:0][CW-1:0]   cnt;
    logic [CHW-1:0]           gnt;
    logic                     gnt_any, wb_done;

    assign is_glb  = (reg_addr[11:8] == 4'h0);
    assign ch_ok   = (reg_addr[11:8] == 4'h1) && (32'(reg_addr[7:6]) < NCH);
    assign acc_ch  = reg_addr[6 +: CHW];
    assign off     = reg_addr[5:0];
    assign wb_done = (q.st == S_WB) && mem_ack;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign sema_wr[c]  = reg_wr && ch_ok && (off == C_SEMA) && (acc_ch == CHW'(c));
        assign sema_dec[c] = wb_done && (q.err == '0) && (q.ch == CHW'(c)) && q.desc[W_CTL0][1];
        assign elig[c]     = q.en[c] && (cnt[c] != '0) && !q.park[c];

        cmdchan_sema #(.CW(CW), .DW(DW)) u_sema (
            .clk     (clk),
            .rst_n   (rst_n),
            .add_en  (sema_wr[c]),
            .add_val (reg_wdata),
            .dec     (sema_dec[c]),
            .count   (cnt[c])
        );
    end

    cmdchan_pick #(.N(NCH), .IW(CHW)) u_pick (
        .req (elig),
        .idx (gnt),
        .any (gnt_any)
    );

    always_comb begin
        d      = q;
        hw_set = '0;

        // descriptor sequencer
        case (q.st)
            S_IDLE: if (gnt_any) begin
                d.st   = S_FETCH;
                d.ch   = gnt;
                d.base = q.cptr[gnt];
                d.idx  = '0;
                d.err  = '0;
            end
            S_FETCH: if (mem_ack) begin
                if (q.idx != IDXW'(W_STAT)) d.desc[q.idx] = mem_rdata;
                d.idx = q.idx + 1'b1;
                if (q.idx == IDXW'(W_STAT)) d.st = S_START;
            end
            S_START: d.st = S_WAIT;
            S_WAIT: if (eng_done) begin
                d.err = eng_err;
                d.st  = S_WB;
            end
            S_WB: if (mem_ack) begin
                d.st = S_IDLE;
                if (q.err != '0) begin
                    d.cerr[q.ch] = q.err;
                    d.park[q.ch] = 1'b1;
                    hw_set[q.ch] = 1'b1;
                end else begin
                    hw_set[q.ch] = q.desc[W_CTL0][0];
                    if (q.desc[W_LINK] != '0) d.cptr[q.ch] = q.desc[W_LINK];
                    else                      d.park[q.ch] = 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase

        // software writes; a pointer or credit write wakes a halted channel
        if (reg_wr) begin
            if (is_glb) begin
                if (reg_addr[7:0] == G_CLR) d.pend = q.pend & ~reg_wdata[NCH-1:0];
                if (reg_addr[7:0] == G_EN)  d.en   = reg_wdata[7:0];
            end else if (ch_ok) begin
                case (off)
                    C_PTR:  begin d.cptr[acc_ch] = reg_wdata; d.park[acc_ch] = 1'b0; end
                    C_SEMA: d.park[acc_ch] = 1'b0;
                    C_SCLR: d.cerr[acc_ch] = q.cerr[acc_ch] & ~reg_wdata[EW-1:0];
                    default: ;
                endcase
            end
        end
        d.pend = d.pend | hw_set;

        // registered read data
        if (reg_rd) begin
            d.rdata = '0;
            if (is_glb) begin
                if (reg_addr[7:0] == G_PEND) d.rdata = DW'(q.pend);
                if (reg_addr[7:0] == G_EN)   d.rdata = DW'(q.en);
            end else if (ch_ok) begin
                case (off)
                    C_PTR:   d.rdata = q.cptr[acc_ch];
                    C_SEMA:  d.rdata = DW'(cnt[acc_ch]);
                    C_STAT:  d.rdata = DW'(q.cerr[acc_ch]);
                    default: d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign reg_rdata   = q.rdata;
    assign mem_req     = (q.st == S_FETCH) || (q.st == S_WB);
    assign mem_we      = (q.st == S_WB);
    assign mem_addr    = q.base + ((q.st == S_WB) ? DW'(W_STAT * 4) : DW'({q.idx, 2'b00}));
    assign mem_wdata   = DW'(q.err);
    assign eng_start   = (q.st == S_START);
    assign eng_ctrl0   = q.desc[1];
    assign eng_ctrl1   = q.desc[2];
    assign eng_src     = q.desc[3];
    assign eng_dst     = q.desc[4];
    assign eng_size    = q.desc[5];
    assign eng_payload = q.desc[6];
    assign irq         = |q.pend;
endmodule

// File: rtl/cmdchan_ctrl_chk.sv
module cmdchan_ctrl_chk #(
    parameter int DW = 32,
    parameter int EW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [DW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          eng_start,
    input logic          eng_done,
    input logic          irq
);
    logic busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         busy_q <= 1'b0;
        else if (eng_start) busy_q <= 1'b1;
        else if (eng_done)  busy_q <= 1'b0;
    end

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R6
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R6
    single_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !busy_q);

    // R6
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !mem_req);

    // R7
    code_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[DW-1:EW] == '0);

    // R12
    irq_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mem_req && mem_we && mem_ack));
endmodule

bind cmdchan_ctrl cmdchan_ctrl_chk #(.DW(DW), .EW(EW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .irq       (irq)
);

// File: tb/cmdchan_ctrl_bench.sv
`timescale 1ns/1ps
module cmdchan_ctrl_bench;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        eng_start, eng_done = 1'b0;
    logic [31:0] eng_ctrl0, eng_ctrl1, eng_src, eng_dst, eng_size, eng_payload;
    logic [7:0]  eng_err = '0;
    logic        irq;

    cmdchan_ctrl u_cmdchan_ctrl (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .eng_start(eng_start), .eng_ctrl0(eng_ctrl0), .eng_ctrl1(eng_ctrl1),
        .eng_src(eng_src), .eng_dst(eng_dst), .eng_size(eng_size),
        .eng_payload(eng_payload), .eng_done(eng_done), .eng_err(eng_err),
        .irq(irq)
    );

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    logic [31:0] mem    [0:255];
    logic [31:0] wb_log [0:255] = '{default: 32'hDEADBEEF};
    logic [31:0] exp_arr [0:63];
    int          exp_wr = 0, exp_rd = 0;
    logic [3:0]  m_pend = '0;
    int          eng_cnt = 0;
    logic [31:0] cur_ctrl0 = '0;
    logic [7:0]  cur_err = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // engine result code chosen by the source word
    function automatic logic [7:0] code_of(input logic [31:0] s);
        return (s[31:24] == 8'hE0) ? s[7:0] : 8'h00;
    endfunction

    // reference model, memory and engine responder (falling edge)
    always @(negedge clk) begin
        logic [3:0] nxt;
        if (rst_n) begin
            chk("R12 irq follows pending flags", {31'b0, irq}, {31'b0, |m_pend});
            if (eng_start) begin
                if (exp_rd >= exp_wr) begin
                    chk("R5/R11 unexpected descriptor start", eng_src, 32'hFFFF_FFFF);
                end else begin
                    chk("R11 service order", eng_src, exp_arr[exp_rd]);
                    exp_rd++;
                end
                chk("R6 size word", eng_size, 32'd16);
                chk("R6 destination word", eng_dst, eng_src + 32'h100);
                cur_ctrl0 = eng_ctrl0;
                cur_err   = code_of(eng_src);
                eng_cnt   = LAT;
            end
        end
        nxt = m_pend;
        if (reg_wr && reg_addr == 12'h018) nxt = nxt & ~reg_wdata[3:0];
        if (mem_req && mem_we) begin
            chk("R7 status word written", mem_wdata, {24'b0, cur_err});
            wb_log[mem_addr[9:2]] = mem_wdata;
            if (cur_err != 0 || cur_ctrl0[0]) nxt[mem_addr[9:8]] = 1'b1;
        end
        m_pend    = nxt;
        mem_ack   = mem_req;
        mem_rdata = mem[mem_addr[9:2]];
        eng_done  = 1'b0;
        eng_err   = '0;
        if (eng_cnt > 0) begin
            eng_cnt--;
            if (eng_cnt == 0) begin
                eng_done = 1'b1;
                eng_err  = cur_err;
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        reg_addr = a; reg_rd = 1'b1;
        @(posedge clk); #1;
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic put_desc(input int w, input logic [31:0] link, input logic [31:0] c0,
                            input logic [31:0] src);
        mem[w]   = link;  mem[w+1] = c0;          mem[w+2] = 32'h0;
        mem[w+3] = src;   mem[w+4] = src + 32'h100; mem[w+5] = 32'd16;
        mem[w+6] = 32'h0; mem[w+7] = 32'hDEADBEEF;
    endtask

    task automatic expect_src(input logic [31:0] s);
        exp_arr[exp_wr] = s;
        exp_wr++;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] e);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, e);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq low", {31'b0, irq}, 32'd0);
        chk("R1 no memory request", {31'b0, mem_req}, 32'd0);
        chk("R1 no engine start", {31'b0, eng_start}, 32'd0);
        rd_chk("R1 pending word", 12'h010, 32'h0);
        rd_chk("R1 enable register", 12'h020, 32'h0);
        rd_chk("R1 semaphore ch0", 12'h110, 32'h0);
        rd_chk("R1 status ch3", 12'h1E0, 32'h0);

        // R2 enable register keeps only low 8 bits
        wr(12'h020, 32'hABCD_00F0);
        rd_chk("R2 enable readback", 12'h020, 32'h0000_00F0);

        // R3 saturation on ch3
        wr(12'h1D0, 32'd200);
        wr(12'h1D0, 32'd200);
        rd_chk("R3 count saturates", 12'h1D0, 32'd255);
        wr(12'h1D0, 32'd0);
        rd_chk("R3 adding zero", 12'h1D0, 32'd255);

        // R5 disabled channel does nothing
        put_desc(0, 32'h0, 32'h3, 32'h5000_0001);
        wr(12'h100, 32'h0);
        wr(12'h110, 32'd1);
        repeat (40) @(posedge clk);
        rd_chk("R5 count untouched while disabled", 12'h110, 32'd1);
        chk("R5 no writeback while disabled", wb_log[7], 32'hDEADBEEF);

        // R4 R6 R7 R8 single descriptor on ch0
        expect_src(32'h5000_0001);
        wr(12'h020, 32'h01);
        repeat (40) @(posedge clk);
        chk("R4 descriptor executed", exp_rd, exp_wr);
        chk("R7 status word in memory", wb_log[7], 32'h0);
        rd_chk("R8 pending set by control0 bit0", 12'h010, 32'h1);
        rd_chk("R8 count decremented", 12'h110, 32'd0);
        wr(12'h018, 32'h1);
        chk("R12 irq cleared", {31'b0, irq}, 32'd0);

        // R9 chain on ch1 limited by credit
        put_desc(64, 32'd72*4, 32'h2, 32'h5100_0001);
        put_desc(72, 32'd80*4, 32'h2, 32'h5100_0002);
        put_desc(80, 32'h0,    32'h3, 32'h5100_0003);
        wr(12'h140, 32'd64*4);
        wr(12'h150, 32'd2);
        expect_src(32'h5100_0001);
        expect_src(32'h5100_0002);
        wr(12'h020, 32'h02);
        repeat (80) @(posedge clk);
        chk("R9 two chained descriptors ran", exp_rd, exp_wr);
        rd_chk("R9 count used up", 12'h150, 32'd0);
        rd_chk("R8 pointer follows link", 12'h140, 32'd80*4);
        rd_chk("R8 no pending without bit0", 12'h010, 32'h0);
        expect_src(32'h5100_0003);
        wr(12'h150, 32'd1);
        repeat (40) @(posedge clk);
        chk("R9 credit resumes chain", exp_rd, exp_wr);
        rd_chk("R8 pending ch1", 12'h010, 32'h2);
        wr(12'h018, 32'h2);

        // R9 zero link halts with count kept (ch2)
        put_desc(128, 32'h0, 32'h1, 32'h5200_0001);
        wr(12'h180, 32'd128*4);
        wr(12'h190, 32'd1);
        expect_src(32'h5200_0001);
        wr(12'h020, 32'h04);
        repeat (80) @(posedge clk);
        chk("R9 ran exactly once", exp_rd, exp_wr);
        rd_chk("R9 count kept at halt", 12'h190, 32'd1);
        rd_chk("R8 pending ch2", 12'h010, 32'h4);
        wr(12'h018, 32'h4);

        // R10 engine error on ch3
        put_desc(192, 32'd200*4, 32'h0, 32'hE000_005A);
        put_desc(200, 32'h0, 32'h3, 32'h5300_0001);
        wr(12'h1C0, 32'd192*4);
        expect_src(32'hE000_005A);
        wr(12'h020, 32'h08);
        repeat (80) @(posedge clk);
        chk("R10 one descriptor then stop", exp_rd, exp_wr);
        rd_chk("R10 status holds code", 12'h1E0, 32'h5A);
        rd_chk("R10 pending despite bit0 clear", 12'h010, 32'h8);
        chk("R10 code written back", wb_log[199], 32'h5A);
        rd_chk("R10 no decrement", 12'h1D0, 32'd255);
        rd_chk("R10 link not followed", 12'h1C0, 32'd192*4);
        wr(12'h1E8, 32'hFFFF_FFFF);
        rd_chk("R10 status cleared", 12'h1E0, 32'h0);
        wr(12'h018, 32'h8);

        // R11 priority between ch0 and ch2
        wr(12'h020, 32'h00);
        put_desc(8,   32'h0, 32'h1, 32'h5000_0010);
        put_desc(136, 32'h0, 32'h1, 32'h5200_0010);
        wr(12'h100, 32'd8*4);
        wr(12'h110, 32'd1);
        wr(12'h180, 32'd136*4);
        expect_src(32'h5000_0010);
        expect_src(32'h5200_0010);
        wr(12'h020, 32'h05);
        repeat (80) @(posedge clk);
        chk("R11 both served", exp_rd, exp_wr);
        rd_chk("R12 both flags pending", 12'h010, 32'h5);
        wr(12'h018, 32'hF);
        chk("R12 irq low after clear", {31'b0, irq}, 32'd0);
        rd_chk("R2 out-of-map read is zero", 12'h030, 32'h0);

        repeat (5) @(posedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule